// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This host-side block returns a two-wire serial memory target to a known idle state after the host lost track of a transfer, for example after a host-only reset. The target has no reset pin. Bus conditions are the only way to resynchronise it. A target that is stuck mid-byte may be holding SDA low for an acknowledge or for a read-data bit. The sequencer releases SDA and toggles SCL nine times, which lets the target finish its current bit and byte. It then forms a start condition at once, so that no stray clock can arm a write, and closes with a stop condition.

The block drives only pull-down enables for the two open-drain lines. A released line is pulled high by the bus resistor and is never driven high. Each SCL low or high phase lasts `HALF_PERIOD` system clocks, and the start and stop edges are spaced the same way. The sequence runs once after reset, because recovery is advisable at power-up. After that it runs on each accepted trigger. A one-cycle done pulse marks the end of each run.

Top module: `bus_unstick_seq`

## Requirements
- R1: While rst_ni is low, scl_pd_o, sda_pd_o, busy_o and done_o are all 0 (both lines released).
- R2: After a run is accepted, sda_pd_o stays 0 while SCL is pulsed exactly 9 times. Each pulse is HALF_PERIOD cycles with scl_pd_o=1, then HALF_PERIOD cycles with scl_pd_o=0.
- R3: The cycle after the 9th high phase ends, sda_pd_o becomes 1 while scl_pd_o is still 0 (a start condition). No SCL low phase comes between the 9th pulse and this start.
- R4: The start holds SDA low with SCL released for HALF_PERIOD cycles. It then pulls SCL low, with SDA still low, for HALF_PERIOD cycles.
- R5: The stop releases SCL with SDA low for HALF_PERIOD cycles. It then releases SDA, which rises only while SCL is released.
- R6: HALF_PERIOD cycles after SDA is released, done_o is 1 for exactly one cycle. busy_o is 1 from the cycle after acceptance through the final phase, and 0 in the done cycle.
- R7: trig_i (active high, sampled on the rising clock edge) has no effect while busy_o is 1. The running sequence is not altered, and no further run is queued.
- R8: With AUTO_START=1, a run is accepted on the first clock edge after reset is released, with no trigger.
- R9: A trigger sampled in the done cycle is accepted, and a new run starts on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Request a recovery run, sampled on the rising edge |
| scl_pd_o | output | 1 | SCL pull-down enable (1 = drive low) |
| sda_pd_o | output | 1 | SDA pull-down enable (1 = drive low) |
| busy_o | output | 1 | Recovery run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The done pulse and the acceptance of a new trigger can fall in the same cycle: the idle cycle that carries done_o is also the first cycle in which a trigger counts. The bench raises trig_i in the very cycle in which it sees done_o. A queue-based reference model then expects a one-cycle done pulse, followed immediately by a full new waveform with no gap and no lost request. The bench compares every output on every clock. It also checks separately that triggers sent during a run leave the waveform untouched and queue nothing.

// File: rtl/brec_pkg.sv
package brec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_STA_HOLD,
    ST_STA_LOW,
    ST_STP_HIGH,
    ST_STP_REL
  } brec_state_e;
endpackage

// File: rtl/brec_timer.sv
module brec_timer #(
  parameter int unsigned HALF_PERIOD = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R2: a phase never outlasts HALF_PERIOD cycles
  p_phase_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R2: every phase starts counting from zero
  p_idle_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/brec_count.sv
module brec_count #(
  parameter int unsigned LIMIT = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // R2: the dummy clock count never exceeds LIMIT
  p_clk_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);
endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq
  import brec_pkg::*;
#(
  parameter int unsigned HALF_PERIOD  = 1000,
  parameter int unsigned DUMMY_CLOCKS = 9,
  parameter bit          AUTO_START   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic scl_pd_o,
  output logic sda_pd_o,
  output logic busy_o,
  output logic done_o
);
  brec_state_e state_q, state_d;
  logic tick, last_clk, boot_q, done_q, accept;

  brec_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  brec_count #(.LIMIT(DUMMY_CLOCKS)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .inc_i  ((state_q == ST_CLK_HI) && tick),
    .last_o (last_clk)
  );

  assign accept = (state_q == ST_IDLE) && (trig_i || boot_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (accept) state_d = ST_CLK_LO;
      ST_CLK_LO:   if (tick)   state_d = ST_CLK_HI;
      ST_CLK_HI:   if (tick)   state_d = last_clk ? ST_STA_HOLD : ST_CLK_LO;
      ST_STA_HOLD: if (tick)   state_d = ST_STA_LOW;
      ST_STA_LOW:  if (tick)   state_d = ST_STP_HIGH;
      ST_STP_HIGH: if (tick)   state_d = ST_STP_REL;
      ST_STP_REL:  if (tick)   state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      boot_q  <= AUTO_START;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      boot_q  <= 1'b0;
      done_q  <= (state_q == ST_STP_REL) && tick;
    end
  end

  // open-drain: only pull-down enables, release = 0
  assign scl_pd_o = (state_q == ST_CLK_LO) || (state_q == ST_STA_LOW);
  assign sda_pd_o = (state_q == ST_STA_HOLD) || (state_q == ST_STA_LOW) ||
                    (state_q == ST_STP_HIGH);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  // R3: SDA may only fall while SCL is released (start)
  p_start_scl_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_o) |-> !scl_pd_o);

  // R5: SDA may only rise while SCL is released (stop)
  p_stop_scl_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pd_o) |-> !scl_pd_o);

  // R6: done is a single-cycle pulse seen outside a run
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o ##1 !done_o));

  // R7: between timer ticks the lines hold, whatever trig_i does
  p_hold_while_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick) |=> $stable({scl_pd_o, sda_pd_o, busy_o}));
endmodule

// File: tb/sim_bus_unstick_seq.sv
`timescale 1ns/1ps
module sim_bus_unstick_seq;
  localparam int unsigned HP = 4;
  localparam int unsigned NCLK = 9;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic trig_i = 1'b0;
  logic scl_pd_o, sda_pd_o, busy_o, done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bus_unstick_seq #(.HALF_PERIOD(HP), .DUMMY_CLOCKS(NCLK), .AUTO_START(1'b1)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i),
    .scl_pd_o(scl_pd_o), .sda_pd_o(sda_pd_o), .busy_o(busy_o), .done_o(done_o)
  );

  // reference model: queue of expected {done,busy,scl_pd,sda_pd} per cycle
  logic [3:0] q[$];
  bit boot = 1'b1;
  logic [3:0] expv;

  task automatic push_run();
    for (int i = 0; i < NCLK; i++) begin
      for (int k = 0; k < HP; k++) q.push_back(4'b0110);
      for (int k = 0; k < HP; k++) q.push_back(4'b0100);
    end
    for (int k = 0; k < HP; k++) q.push_back(4'b0101);
    for (int k = 0; k < HP; k++) q.push_back(4'b0111);
    for (int k = 0; k < HP; k++) q.push_back(4'b0101);
    for (int k = 0; k < HP; k++) q.push_back(4'b0100);
    q.push_back(4'b1000);
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      q.delete();
      boot = 1'b1;
    end else begin
      logic [3:0] cur;
      cur = (q.size() != 0) ? q[0] : 4'b0000;
      if (q.size() != 0) void'(q.pop_front());
      if (!cur[2] && (trig_i || boot)) push_run();
      boot = 1'b0;
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison (R2 R4 R5 R6 R7 R8 R9 timing)
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      expv = (q.size() != 0) ? q[0] : 4'b0000;
      check("R2 R4 R5 R6 cycle", {done_o, busy_o, scl_pd_o, sda_pd_o}, expv);
    end
  end

  // event monitor: clock count before start, start before stop
  int pulses = 0;
  bit started = 1'b0;
  logic p_scl = 1'b0, p_sda = 1'b0;
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      pulses = 0; started = 1'b0; p_scl = 1'b0; p_sda = 1'b0;
    end else if (!finished) begin
      if (p_scl && !scl_pd_o && !started) pulses++;
      if (!p_sda && sda_pd_o) begin
        check("R3 start after nine pulses", {3'b0, !scl_pd_o && pulses == NCLK}, 4'b0001);
        started = 1'b1;
      end
      if (p_sda && !sda_pd_o)
        check("R5 stop after start, SCL high", {3'b0, started && !scl_pd_o}, 4'b0001);
      if (done_o) begin pulses = 0; started = 1'b0; end
      p_scl = scl_pd_o; p_sda = sda_pd_o;
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wait_done();
    do @(negedge clk_i); while (!done_o);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check("R1 reset idle", {done_o, busy_o, scl_pd_o, sda_pd_o}, 4'b0000);
    rst_ni = 1'b1;
    // R8: run launches without trigger
    @(negedge clk_i);
    check("R8 auto start", {3'b0, busy_o}, 4'b0001);
    wait_done();
    repeat (5) @(negedge clk_i);
    check("R8 single boot run", {3'b0, busy_o}, 4'b0000);

    // plain triggered run
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    check("R2 trigger accepted", {3'b0, busy_o}, 4'b0001);
    // R7: triggers during the run
    repeat (10) @(negedge clk_i);
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    repeat (40) @(negedge clk_i);
    trig_i = 1'b1; repeat (3) @(negedge clk_i); trig_i = 1'b0;
    wait_done();
    repeat (6) @(negedge clk_i);
    check("R7 busy trigger not queued", {3'b0, busy_o}, 4'b0000);

    // R9: trigger in the done cycle
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    wait_done();
    trig_i = 1'b1; @(negedge clk_i); trig_i = 1'b0;
    check("R9 trigger in done cycle", {3'b0, busy_o}, 4'b0001);
    wait_done();

    // level trigger held high: back-to-back runs
    trig_i = 1'b1;
    wait_done();
    @(negedge clk_i);
    trig_i = 1'b0;
    check("R9 held trigger restarts", {3'b0, busy_o}, 4'b0001);
    wait_done();
    repeat (4) @(negedge clk_i);
    check("R6 idle after run", {done_o, busy_o, scl_pd_o, sda_pd_o}, 4'b0000);
    finish_run();
  end
endmodule